// File: doc/BRIEF.md
# Delayed Transaction Retry Matcher

A bridge that answers a non-posted request with retry keeps that request as a pending delayed transaction. It then waits for the initiator to come back with the same cycle. This block decides whether an incoming cycle is that retry. It compares the incoming command, address and byte enables with the fields of the stored entry. It raises a registered hit one cycle after the request strobe. A second flag marks hits that needed a relaxed command comparison.

Relaxed comparison folds related memory commands into a base command, per side of the bridge. Write-and-invalidate folds into plain memory write. Read-line and read-multiple fold into plain memory read. Each bridge side has its own write-fold enable and its own read-fold enable. The enables load together from a configuration input and are cleared by reset, so exact matching is the default. The address and byte enables are always compared exactly. I/O and configuration commands are never folded.

Top module: `dt_retry_match`

## Requirements
- R1: After reset is released, hit_o and alias_hit_o are 0 and every fold enable is clear. A reset in mid-run also clears enables that were set before it.
- R2: A valid request whose command, address and byte enables equal those of a valid stored entry gives hit_o=1 with alias_hit_o=0. This holds in every fold mode.
- R3: With the write-fold enable of the requesting side clear, memory write-and-invalidate (4'hF) and memory write (4'h7) do not match each other.
- R4: With the write-fold enable of the requesting side set, 4'hF and 4'h7 match each other in either direction. The result is hit_o=1 and alias_hit_o=1.
- R5: With the read-fold enable of the requesting side set, memory read-multiple (4'hC), memory read-line (4'hE) and memory read (4'h6) all match one another with alias_hit_o=1. With it clear, they do not match.
- R6: cfg_alias_i bit 2p is the write-fold enable and bit 2p+1 is the read-fold enable of side p. The request side is picked by req_port_i. The enables of one side have no effect on requests from the other side. cfg_load_i=1 captures all enables at the clock edge.
- R7: A request whose address or byte enables differ from the entry in any bit never hits, whatever the fold enables.
- R8: A read command (bit 0 = 0) never matches a write command (bit 0 = 1), whatever the fold enables.
- R9: I/O read/write (4'h2/4'h3) and configuration read/write (4'hA/4'hB) are matched only on an identical code, whatever the fold enables.
- R10: hit_o and alias_hit_o are registered. They reflect the request sampled at the previous clock edge. They are 0 after a cycle with req_valid_i=0 or with ent_valid_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load strobe for the fold enables |
| cfg_alias_i | input | 2*NUM_PORTS | Fold enables: bit 2p write fold, bit 2p+1 read fold, side p |
| req_valid_i | input | 1 | Incoming request strobe |
| req_port_i | input | PORT_W | Side of the bridge the request arrives on |
| req_cmd_i | input | 4 | Incoming bus command code |
| req_addr_i | input | ADDR_W | Incoming address |
| req_be_i | input | BE_W | Incoming byte enables |
| ent_valid_i | input | 1 | Stored entry is pending |
| ent_cmd_i | input | 4 | Stored command code |
| ent_addr_i | input | ADDR_W | Stored address |
| ent_be_i | input | BE_W | Stored byte enables |
| hit_o | output | 1 | Registered retry hit |
| alias_hit_o | output | 1 | Registered flag: the hit needed command folding |

## Verification
The bench builds the block with its defaults: two sides, a 32-bit address and four byte enables. Two sides are enough to show that one side's enables leave the other side's requests alone. The bench does this by setting enables on one side only and sending the same folded pair from each side. With a full-width address and byte-enable field, it can flip a single bit while all fold enables are set. This shows that relaxed mode never widens the address or byte-enable match.

// File: rtl/dt_retry_pkg.sv
package dt_retry_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_IO_RD       = 4'h2;
  localparam logic [CMD_W-1:0] CMD_IO_WR       = 4'h3;
  localparam logic [CMD_W-1:0] CMD_MEM_RD      = 4'h6;
  localparam logic [CMD_W-1:0] CMD_MEM_WR      = 4'h7;
  localparam logic [CMD_W-1:0] CMD_CFG_RD      = 4'hA;
  localparam logic [CMD_W-1:0] CMD_CFG_WR      = 4'hB;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_MULT = 4'hC;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_LINE = 4'hE;
  localparam logic [CMD_W-1:0] CMD_MEM_WR_INV  = 4'hF;

  function automatic logic is_rd_variant(logic [CMD_W-1:0] c);
    return (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
  endfunction

  function automatic logic is_wr_variant(logic [CMD_W-1:0] c);
    return c == CMD_MEM_WR_INV;
  endfunction

  function automatic logic is_io_or_cfg(logic [CMD_W-1:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR) ||
           (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
  endfunction

endpackage

// File: rtl/dt_retry_alias_cfg.sv
module dt_retry_alias_cfg #(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [2*NUM_PORTS-1:0] alias_i,
  input  logic [PORT_W-1:0]      port_i,
  output logic                   wr_en_o,
  output logic                   rd_en_o
);

  logic [NUM_PORTS-1:0] wr_vec;
  logic [NUM_PORTS-1:0] rd_vec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_q;
    logic rd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q <= 1'b0;
        rd_q <= 1'b0;
      end else if (load_i) begin
        wr_q <= alias_i[2*p];
        rd_q <= alias_i[2*p+1];
      end
    end
    assign wr_vec[p] = wr_q;
    assign rd_vec[p] = rd_q;
  end

  always_comb begin
    wr_en_o = 1'b0;
    rd_en_o = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_i == PORT_W'(p)) begin
        wr_en_o = wr_vec[p];
        rd_en_o = rd_vec[p];
      end
    end
  end

endmodule

// File: rtl/dt_retry_cmd_canon.sv
module dt_retry_cmd_canon
  import dt_retry_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             rd_fold_i,
  input  logic             wr_fold_i,
  output logic [CMD_W-1:0] cmd_o
);

  // Folding keeps bit 0, so reads and writes stay apart; I/O and cfg untouched.
  always_comb begin
    cmd_o = cmd_i;
    if (rd_fold_i && is_rd_variant(cmd_i))      cmd_o = CMD_MEM_RD;
    else if (wr_fold_i && is_wr_variant(cmd_i)) cmd_o = CMD_MEM_WR;
  end

endmodule

// File: rtl/dt_retry_field_cmp.sv
module dt_retry_field_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);

  assign eq_o = (a_i == b_i);

endmodule

// File: rtl/dt_retry_match.sv
module dt_retry_match
  import dt_retry_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 32,
  parameter int BE_W      = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_load_i,
  input  logic [2*NUM_PORTS-1:0] cfg_alias_i,
  input  logic                   req_valid_i,
  input  logic [PORT_W-1:0]      req_port_i,
  input  logic [CMD_W-1:0]       req_cmd_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [BE_W-1:0]        req_be_i,
  input  logic                   ent_valid_i,
  input  logic [CMD_W-1:0]       ent_cmd_i,
  input  logic [ADDR_W-1:0]      ent_addr_i,
  input  logic [BE_W-1:0]        ent_be_i,
  output logic                   hit_o,
  output logic                   alias_hit_o
);

  logic             wr_fold, rd_fold;
  logic [CMD_W-1:0] req_canon, ent_canon;
  logic             addr_eq, be_eq, cmd_eq;
  logic             hit_d, alias_d;
  logic             hit_q, alias_q;

  dt_retry_alias_cfg #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W)
  ) cfg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .alias_i(cfg_alias_i),
    .port_i (req_port_i),
    .wr_en_o(wr_fold),
    .rd_en_o(rd_fold)
  );

  dt_retry_cmd_canon req_canon_i (
    .cmd_i    (req_cmd_i),
    .rd_fold_i(rd_fold),
    .wr_fold_i(wr_fold),
    .cmd_o    (req_canon)
  );

  dt_retry_cmd_canon ent_canon_i (
    .cmd_i    (ent_cmd_i),
    .rd_fold_i(rd_fold),
    .wr_fold_i(wr_fold),
    .cmd_o    (ent_canon)
  );

  dt_retry_field_cmp #(.W(ADDR_W)) addr_cmp_i (
    .a_i (req_addr_i),
    .b_i (ent_addr_i),
    .eq_o(addr_eq)
  );

  dt_retry_field_cmp #(.W(BE_W)) be_cmp_i (
    .a_i (req_be_i),
    .b_i (ent_be_i),
    .eq_o(be_eq)
  );

  dt_retry_field_cmp #(.W(CMD_W)) cmd_cmp_i (
    .a_i (req_canon),
    .b_i (ent_canon),
    .eq_o(cmd_eq)
  );

  assign hit_d   = req_valid_i && ent_valid_i && addr_eq && be_eq && cmd_eq;
  assign alias_d = hit_d && (req_cmd_i != ent_cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      alias_q <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      alias_q <= alias_d;
    end
  end

  assign hit_o       = hit_q;
  assign alias_hit_o = alias_q;

endmodule

// File: rtl/dt_retry_match_chk.sv
module dt_retry_match_chk
  import dt_retry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [CMD_W-1:0]  req_cmd_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [BE_W-1:0]   req_be_i,
  input logic              ent_valid_i,
  input logic [CMD_W-1:0]  ent_cmd_i,
  input logic [ADDR_W-1:0] ent_addr_i,
  input logic [BE_W-1:0]   ent_be_i,
  input logic              hit_o,
  input logic              alias_hit_o
);

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_quiet: assert (!hit_o && !alias_hit_o);

  a_r2_exact_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ent_valid_i && req_cmd_i == ent_cmd_i &&
     req_addr_i == ent_addr_i && req_be_i == ent_be_i) |=> (hit_o && !alias_hit_o));

  a_r4_alias_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_hit_o |-> hit_o);

  a_r7_field_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_i != ent_addr_i || req_be_i != ent_be_i) |=> !hit_o);

  a_r8_no_rw_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_cmd_i[0] != ent_cmd_i[0]) |=> !hit_o);

  a_r9_io_cfg_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_io_or_cfg(req_cmd_i) && req_cmd_i != ent_cmd_i) |=> !hit_o);

  a_r10_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || !ent_valid_i) |=> (!hit_o && !alias_hit_o));

endmodule

bind dt_retry_match dt_retry_match_chk #(
  .ADDR_W(ADDR_W),
  .BE_W  (BE_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_cmd_i  (req_cmd_i),
  .req_addr_i (req_addr_i),
  .req_be_i   (req_be_i),
  .ent_valid_i(ent_valid_i),
  .ent_cmd_i  (ent_cmd_i),
  .ent_addr_i (ent_addr_i),
  .ent_be_i   (ent_be_i),
  .hit_o      (hit_o),
  .alias_hit_o(alias_hit_o)
);

// File: tb/dt_retry_match_tb_top.sv
module dt_retry_match_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PORTS  = 2;
  localparam int ADDR_W     = 32;
  localparam int BE_W       = 4;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 32'h1234_5678;
  localparam logic [BE_W-1:0]   BASE_BE   = 4'hF;

  // {cfg[21:18], port[17], rcmd[16:13], ecmd[12:9], addr_mis[8], be_mis[7],
  //  ent_valid[6], exp_hit[5], exp_alias[4], req[3:0]}
  localparam int NV = 21;
  localparam logic [21:0] VEC [NV] = '{
    {4'b0000, 1'b0, 4'h7, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
    {4'b0000, 1'b1, 4'h6, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
    {4'b0000, 1'b0, 4'hF, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    {4'b0001, 1'b0, 4'hF, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4},  // R4
    {4'b0001, 1'b0, 4'h7, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4},  // R4
    {4'b0010, 1'b0, 4'hE, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5
    {4'b0010, 1'b0, 4'hC, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5
    {4'b0000, 1'b0, 4'hE, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    {4'b0010, 1'b0, 4'hE, 4'hC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5
    {4'b0011, 1'b1, 4'hF, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    {4'b1100, 1'b1, 4'hC, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},  // R6
    {4'b1100, 1'b0, 4'hC, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    {4'b1111, 1'b0, 4'hF, 4'h7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    {4'b1111, 1'b0, 4'hE, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    {4'b1111, 1'b0, 4'h6, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
    {4'b1111, 1'b1, 4'hE, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
    {4'b1111, 1'b0, 4'h2, 4'h3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9
    {4'b1111, 1'b0, 4'hA, 4'hB, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9
    {4'b1111, 1'b1, 4'h2, 4'h2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
    {4'b1111, 1'b0, 4'h7, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    {4'b1111, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2}   // R2
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   cfg_load = 1'b0;
  logic [2*NUM_PORTS-1:0] cfg_alias = '0;
  logic                   req_valid = 1'b0;
  logic                   req_port = 1'b0;
  logic [3:0]             req_cmd = '0;
  logic [ADDR_W-1:0]      req_addr = '0;
  logic [BE_W-1:0]        req_be = '0;
  logic                   ent_valid = 1'b0;
  logic [3:0]             ent_cmd = '0;
  logic [ADDR_W-1:0]      ent_addr = '0;
  logic [BE_W-1:0]        ent_be = '0;
  logic                   hit, alias_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dt_retry_match #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .BE_W     (BE_W)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_load_i (cfg_load),
    .cfg_alias_i(cfg_alias),
    .req_valid_i(req_valid),
    .req_port_i (req_port),
    .req_cmd_i  (req_cmd),
    .req_addr_i (req_addr),
    .req_be_i   (req_be),
    .ent_valid_i(ent_valid),
    .ent_cmd_i  (ent_cmd),
    .ent_addr_i (ent_addr),
    .ent_be_i   (ent_be),
    .hit_o      (hit),
    .alias_hit_o(alias_hit)
  );

  task automatic check(input string tag, input logic exp_h, input logic exp_a);
    n_checks++;
    if (hit !== exp_h || alias_hit !== exp_a) begin
      n_fail++;
      $display("FAIL %s: hit=%0b alias=%0b expected hit=%0b alias=%0b",
               tag, hit, alias_hit, exp_h, exp_a);
    end
  endtask

  task automatic load_cfg(input logic [3:0] c);
    @(negedge clk);
    cfg_load  = 1'b1;
    cfg_alias = c;
    @(negedge clk);
    cfg_load  = 1'b0;
  endtask

  // Drive at a falling edge; outputs are valid at the next falling edge.
  task automatic issue(input logic port, input logic [3:0] rc, input logic [3:0] ec,
                       input logic am, input logic bm, input logic ev);
    req_valid = 1'b1;
    req_port  = port;
    req_cmd   = rc;
    ent_cmd   = ec;
    ent_addr  = BASE_ADDR;
    ent_be    = BASE_BE;
    req_addr  = am ? (BASE_ADDR ^ 32'h0000_0100) : BASE_ADDR;
    req_be    = bm ? (BASE_BE ^ 4'b0010) : BASE_BE;
    ent_valid = ev;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", 1'b0, 1'b0);

    // R1: default exact matching on both sides
    issue(1'b0, 4'hF, 4'h7, 1'b0, 1'b0, 1'b1);
    check("R1 default write fold off", 1'b0, 1'b0);
    issue(1'b1, 4'hE, 4'h6, 1'b0, 1'b0, 1'b1);
    check("R1 default read fold off", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      load_cfg(v[21:18]);
      issue(v[17], v[16:13], v[12:9], v[8], v[7], v[6]);
      check($sformatf("R%0d vector %0d", v[3:0], i), v[5], v[4]);
    end

    // R10: output lags the request by one edge and drops after an idle cycle
    load_cfg(4'b0000);
    @(negedge clk);
    req_valid = 1'b1; req_port = 1'b0; req_cmd = 4'h7; ent_cmd = 4'h7;
    req_addr = BASE_ADDR; ent_addr = BASE_ADDR; req_be = BASE_BE; ent_be = BASE_BE;
    ent_valid = 1'b1;
    #1;
    check("R10 no combinational path", 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 hit one cycle later", 1'b1, 1'b0);
    @(negedge clk);
    check("R10 idle cycle clears hit", 1'b0, 1'b0);

    // R1: reset in mid-run clears enables set earlier
    load_cfg(4'b1111);
    issue(1'b0, 4'hF, 4'h7, 1'b0, 1'b0, 1'b1);
    check("R4 fold before reset", 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 outputs in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b0, 4'hF, 4'h7, 1'b0, 1'b0, 1'b1);
    check("R1 write fold cleared by reset", 1'b0, 1'b0);
    issue(1'b1, 4'hC, 4'h6, 1'b0, 1'b0, 1'b1);
    check("R1 read fold cleared by reset", 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule